// File: doc/BRIEF.md
# Daisy-Chain Serial Configuration Loader

This block takes in a configuration bitstream one bit at a time, on each rising edge of a configuration clock. It first looks for a sync word. It then reads a length field and an option flag, and packs the number of bits named by the length field into words for a local frame buffer. It never stores the bits that come before the sync word, or any bit after its own share. Those bits are repeated on a serial output that feeds the next device in a chain. The serial output changes on the falling clock edge, so the next device can sample it on the following rising edge.

In master mode the block makes the configuration clock itself by dividing the system clock. The clock starts at a slow rate. If the option flag in the header is set, the clock switches to a rate eight times faster. An external serial memory, enabled by an active-low chip-enable output, supplies one new bit after each rising edge. In slave mode the clock comes in from an upstream device. An active-low program input restarts the whole sequence.

All logic runs on the system clock `clk`. The configuration clock edges reach the logic as single-cycle event strobes. In slave mode these strobes come from a three-stage synchroniser; in master mode they come from the divider.

Top module: `cfgload_top`

## Requirements
- R1: A data bit on `din` is taken on each rising edge of the configuration clock. In slave mode that clock is `cclkIn`; in master mode it is `cclkOut`.
- R2: `dout` changes only on a falling edge of the configuration clock. When no bit is being forwarded, `dout` is high.
- R3: Forwarding rule. Every bit up to and including the last bit of the sync word is repeated on `dout`, and so is every bit after this device's own data. The header bits and the device's own data bits are not repeated; `dout` shows 1 in their place.
- R4: A forwarded bit appears on `dout` at the falling edge that follows its capture in slave mode (0.5 clock periods). In master mode it appears at the falling edge that follows the next rising edge (1.5 clock periods).
- R5: In master mode each clock phase lasts SLOW_HALF system cycles (default 16, so a period of 32) until the option flag is read. If the flag is 1, each phase then lasts SLOW_HALF/8 system cycles (a period of 4). If the flag is 0, the rate stays slow.
- R6: The master clock changes rate only where a low phase begins. The period that contains the rate change is one slow high phase plus one fast low phase (18 cycles by default). No phase is ever shorter than a fast phase.
- R7: Stream format, sent MSB first: a sync word SYNC_WORD (default 8'hB4), then a 24-bit length L, then one option flag bit, then L data bits for this device. Any number of leading bits may come before the sync word. If the sync word never appears, the block stores nothing and forwards every bit.
- R8: The data bits are shifted into WORD_W-bit words (default 8), earliest bit most significant. A word is written to the frame buffer as a one-cycle `fbWrEn` pulse when it is full or when it holds the last data bit. Word addresses start at 0 and count up. A last partial word is right-aligned, with zeros above it.
- R9: `done` rises at the first rising edge after the last data bit is captured. When L is 0, it rises at the first rising edge after the option flag. It stays high until program, and no frame-buffer write occurs while it is high.
- R10: `memCeN` is low from the release of program until `done` rises, and high from then on.
- R11: While `progN` is low, `done` and `memCeN` are held low, the master clock is held low, and the rate, counters and sync search return to their start state.
- R12: `cclkOe` is high in master mode and low in slave mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| progN | input | 1 | Active-low program / restart |
| masterMode | input | 1 | 1 = generate configuration clock, 0 = take it from cclkIn |
| cclkIn | input | 1 | External configuration clock (slave mode) |
| din | input | 1 | Serial configuration data |
| cclkOut | output | 1 | Generated configuration clock (master mode, else 0) |
| cclkOe | output | 1 | Drive enable for the configuration clock pin |
| dout | output | 1 | Serial data to the next device in the chain |
| done | output | 1 | Own configuration complete |
| memCeN | output | 1 | Active-low enable for the external serial memory |
| fbWrEn | output | 1 | Frame-buffer write strobe |
| fbAddr | output | ADDR_W | Frame-buffer word address |
| fbData | output | WORD_W | Frame-buffer word data |

## Verification
The assertions assume that `masterMode` changes only while `progN` is low. They also assume that each phase of `cclkIn` is much longer than the three-cycle synchroniser, so that every external edge gives exactly one event strobe. The bench changes the mode only while program is held low, and it drives each `cclkIn` phase for ten system cycles. In master mode the bench behaves like the serial memory: it presents the next bit at the first system-clock falling edge after each rising edge of `cclkOut`. This keeps `din` stable through every capture.

// File: rtl/cfgload_pkg.sv
package cfgload_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_HEADER,
    ST_FLAG,
    ST_LOAD,
    ST_DRAIN,
    ST_PASS
  } loadState_e;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic capture;   // rising configuration edge: take din
    logic launch;    // falling configuration edge: update dout
    logic forward;   // bit taken now belongs on dout
    logic shiftSync; // bit goes into the sync window
    logic shiftLen;  // bit goes into the length field
    logic storeBit;  // bit is one of this device's data bits
    logic lastBit;   // this data bit is the final one
    logic clearAll;  // program held low
  } dpStrobe_t;

endpackage

// File: rtl/cfgload_clkgen.sv
module cfgload_clkgen #(
  parameter int SLOW_HALF  = 16,
  parameter int FAST_RATIO = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic progN,
  input  logic masterMode,
  input  logic fastReq,
  input  logic cclkIn,
  output logic cclkOut,
  output logic cclkOe,
  output logic riseEv,
  output logic fallEv
);

  localparam int FAST_HALF = SLOW_HALF / FAST_RATIO;
  localparam int CNT_W     = $clog2(SLOW_HALF + 1);
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_HALF - 1);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_HALF - 1);

  logic [CNT_W-1:0] phaseCnt;
  logic             cclkReg;
  logic             fastCur;
  logic [2:0]       inSync;
  logic             toggle;
  logic [CNT_W-1:0] phaseLast;

  assign phaseLast = fastCur ? FAST_LAST : SLOW_LAST;
  assign toggle    = masterMode && progN && (phaseCnt == phaseLast);

  // Divider: the rate register is reloaded only as a high phase ends,
  // so every phase runs a whole number of cycles at a single rate.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
      cclkReg  <= 1'b0;
      fastCur  <= 1'b0;
    end else if (!progN || !masterMode) begin
      phaseCnt <= '0;
      cclkReg  <= 1'b0;
      fastCur  <= 1'b0;
    end else if (toggle) begin
      phaseCnt <= '0;
      cclkReg  <= !cclkReg;
      if (cclkReg) fastCur <= fastReq;
    end else begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  // Synchroniser for the external clock.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inSync <= '0;
    else       inSync <= {inSync[1:0], cclkIn};
  end

  always_comb begin
    if (masterMode) begin
      riseEv = toggle && !cclkReg;
      fallEv = toggle && cclkReg;
    end else begin
      riseEv = progN && inSync[1] && !inSync[2];
      fallEv = progN && !inSync[1] && inSync[2];
    end
  end

  assign cclkOut = masterMode && cclkReg;
  assign cclkOe  = masterMode;

endmodule

// File: rtl/cfgload_ctrl.sv
module cfgload_ctrl
  import cfgload_pkg::*;
#(
  parameter int LEN_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             progN,
  input  logic             riseEv,
  input  logic             fallEv,
  input  logic             dinBit,
  input  logic             syncHit,
  input  logic [LEN_W-1:0] lenValue,
  output dpStrobe_t        stb,
  output logic             fastReq,
  output logic             done,
  output logic             memCeN
);

  localparam int HDR_W = $clog2(LEN_W);
  localparam logic [HDR_W-1:0] HDR_LAST = HDR_W'(LEN_W - 1);

  loadState_e       state;
  logic [HDR_W-1:0] hdrCnt;
  logic [LEN_W-1:0] bitCnt;
  logic             isLast;

  assign isLast = (bitCnt == (lenValue - LEN_W'(1)));

  always_comb begin
    stb           = '0;
    stb.capture   = riseEv;
    stb.launch    = fallEv;
    stb.forward   = (state == ST_HUNT) || (state == ST_DRAIN) || (state == ST_PASS);
    stb.shiftSync = riseEv && (state == ST_HUNT);
    stb.shiftLen  = riseEv && (state == ST_HEADER);
    stb.storeBit  = riseEv && (state == ST_LOAD);
    stb.lastBit   = isLast;
    stb.clearAll  = !progN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_HUNT;
      hdrCnt  <= '0;
      bitCnt  <= '0;
      fastReq <= 1'b0;
      done    <= 1'b0;
      memCeN  <= 1'b0;
    end else if (!progN) begin
      state   <= ST_HUNT;
      hdrCnt  <= '0;
      bitCnt  <= '0;
      fastReq <= 1'b0;
      done    <= 1'b0;
      memCeN  <= 1'b0;
    end else if (riseEv) begin
      case (state)
        ST_HUNT: begin
          if (syncHit) begin
            state  <= ST_HEADER;
            hdrCnt <= '0;
          end
        end
        ST_HEADER: begin
          hdrCnt <= hdrCnt + 1'b1;
          if (hdrCnt == HDR_LAST) state <= ST_FLAG;
        end
        ST_FLAG: begin
          fastReq <= dinBit;
          bitCnt  <= '0;
          state   <= (lenValue == '0) ? ST_DRAIN : ST_LOAD;
        end
        ST_LOAD: begin
          bitCnt <= bitCnt + 1'b1;
          if (isLast) state <= ST_DRAIN;
        end
        ST_DRAIN: begin
          done   <= 1'b1;
          memCeN <= 1'b1;
          state  <= ST_PASS;
        end
        default: state <= ST_PASS;
      endcase
    end
  end

endmodule

// File: rtl/cfgload_datapath.sv
module cfgload_datapath
  import cfgload_pkg::*;
#(
  parameter int                SYNC_W    = 8,
  parameter logic [SYNC_W-1:0] SYNC_WORD = 8'hB4,
  parameter int                LEN_W     = 24,
  parameter int                WORD_W    = 8,
  parameter int                ADDR_W    = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              din,
  input  dpStrobe_t         stb,
  output logic              syncHit,
  output logic [LEN_W-1:0]  lenValue,
  output logic              dout,
  output logic              fbWrEn,
  output logic [ADDR_W-1:0] fbAddr,
  output logic [WORD_W-1:0] fbData
);

  localparam int FILL_W = $clog2(WORD_W);
  localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(WORD_W - 1);

  logic [SYNC_W-2:0] syncHist;
  logic [SYNC_W-1:0] syncWindow;
  logic [WORD_W-2:0] wordAcc;
  logic [WORD_W-1:0] nextWord;
  logic [FILL_W-1:0] wordFill;
  logic [ADDR_W-1:0] wordAddr;
  logic              capBit, capFwd, dlyBit, dlyFwd;

  assign syncWindow = {syncHist, din};
  assign syncHit    = (syncWindow == SYNC_WORD);
  assign nextWord   = {wordAcc, din};

  // Sync search and header field.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncHist <= '1;
      lenValue <= '0;
    end else if (stb.clearAll) begin
      syncHist <= '1;
      lenValue <= '0;
    end else begin
      if (stb.shiftSync) syncHist <= syncWindow[SYNC_W-2:0];
      if (stb.shiftLen)  lenValue <= {lenValue[LEN_W-2:0], din};
    end
  end

  // Word packing for the frame buffer.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordAcc  <= '0;
      wordFill <= '0;
      wordAddr <= '0;
      fbWrEn   <= 1'b0;
      fbAddr   <= '0;
      fbData   <= '0;
    end else if (stb.clearAll) begin
      wordAcc  <= '0;
      wordFill <= '0;
      wordAddr <= '0;
      fbWrEn   <= 1'b0;
      fbAddr   <= '0;
      fbData   <= '0;
    end else if (stb.storeBit) begin
      if (wordFill == FILL_LAST || stb.lastBit) begin
        fbWrEn   <= 1'b1;
        fbData   <= nextWord;
        fbAddr   <= wordAddr;
        wordAddr <= wordAddr + 1'b1;
        wordFill <= '0;
        wordAcc  <= '0;
      end else begin
        fbWrEn   <= 1'b0;
        wordAcc  <= nextWord[WORD_W-2:0];
        wordFill <= wordFill + 1'b1;
      end
    end else begin
      fbWrEn <= 1'b0;
    end
  end

  // Chain output: every bit carries its forward tag from capture on.
  // Master mode reads the second stage, slave mode the first.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capBit <= 1'b1;
      capFwd <= 1'b0;
      dlyBit <= 1'b1;
      dlyFwd <= 1'b0;
      dout   <= 1'b1;
    end else if (stb.clearAll) begin
      capBit <= 1'b1;
      capFwd <= 1'b0;
      dlyBit <= 1'b1;
      dlyFwd <= 1'b0;
      dout   <= 1'b1;
    end else begin
      if (stb.capture) begin
        capBit <= din;
        capFwd <= stb.forward;
        dlyBit <= capBit;
        dlyFwd <= capFwd;
      end
      if (stb.launch) begin
        if (masterMode) dout <= dlyFwd ? dlyBit : 1'b1;
        else            dout <= capFwd ? capBit : 1'b1;
      end
    end
  end

endmodule

// File: rtl/cfgload_top.sv
module cfgload_top
  import cfgload_pkg::*;
#(
  parameter int                SYNC_W     = 8,
  parameter logic [SYNC_W-1:0] SYNC_WORD  = 8'hB4,
  parameter int                LEN_W      = 24,
  parameter int                WORD_W     = 8,
  parameter int                ADDR_W     = 12,
  parameter int                SLOW_HALF  = 16,
  parameter int                FAST_RATIO = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              progN,
  input  logic              masterMode,
  input  logic              cclkIn,
  input  logic              din,
  output logic              cclkOut,
  output logic              cclkOe,
  output logic              dout,
  output logic              done,
  output logic              memCeN,
  output logic              fbWrEn,
  output logic [ADDR_W-1:0] fbAddr,
  output logic [WORD_W-1:0] fbData
);

  dpStrobe_t        stb;
  logic             riseEv, fallEv, fastReq, syncHit;
  logic [LEN_W-1:0] lenValue;

  cfgload_clkgen #(
    .SLOW_HALF (SLOW_HALF),
    .FAST_RATIO(FAST_RATIO)
  ) u_clkgen (
    .clk       (clk),
    .rstN      (rstN),
    .progN     (progN),
    .masterMode(masterMode),
    .fastReq   (fastReq),
    .cclkIn    (cclkIn),
    .cclkOut   (cclkOut),
    .cclkOe    (cclkOe),
    .riseEv    (riseEv),
    .fallEv    (fallEv)
  );

  cfgload_ctrl #(
    .LEN_W(LEN_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .progN   (progN),
    .riseEv  (riseEv),
    .fallEv  (fallEv),
    .dinBit  (din),
    .syncHit (syncHit),
    .lenValue(lenValue),
    .stb     (stb),
    .fastReq (fastReq),
    .done    (done),
    .memCeN  (memCeN)
  );

  cfgload_datapath #(
    .SYNC_W   (SYNC_W),
    .SYNC_WORD(SYNC_WORD),
    .LEN_W    (LEN_W),
    .WORD_W   (WORD_W),
    .ADDR_W   (ADDR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .masterMode(masterMode),
    .din       (din),
    .stb       (stb),
    .syncHit   (syncHit),
    .lenValue  (lenValue),
    .dout      (dout),
    .fbWrEn    (fbWrEn),
    .fbAddr    (fbAddr),
    .fbData    (fbData)
  );

endmodule

// File: rtl/cfgload_checker.sv
module cfgload_checker (
  input logic clk,
  input logic rstN,
  input logic progN,
  input logic masterMode,
  input logic cclkOut,
  input logic dout,
  input logic done,
  input logic memCeN,
  input logic fbWrEn
);

  // R9: done holds while program stays released
  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (done && progN) |=> done);

  // R9: no frame-buffer write once done
  assert_no_write_after_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    fbWrEn |-> !done);

  // R8: write strobes are single-cycle pulses
  assert_single_write_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    fbWrEn |=> !fbWrEn);

  // R11: program clears done, memory enable and the clock
  assert_prog_clears_R11: assert property (@(posedge clk) disable iff (!rstN)
    !progN |=> (!done && !memCeN && !cclkOut));

  // R6: no master clock phase shorter than two system cycles
  assert_no_runt_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && progN && $rose(cclkOut)) |=> cclkOut);

  assert_no_runt_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && progN && $fell(cclkOut)) |=> (!cclkOut || !progN));

  // R2: in master mode dout moves only with a falling clock
  assert_dout_on_fall_R2: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && progN && $past(progN) && !$stable(dout)) |-> $fell(cclkOut));

endmodule

bind cfgload_top cfgload_checker u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .progN     (progN),
  .masterMode(masterMode),
  .cclkOut   (cclkOut),
  .dout      (dout),
  .done      (done),
  .memCeN    (memCeN),
  .fbWrEn    (fbWrEn)
);

// File: tb/tb_cfgload_top.sv
module tb_cfgload_top;

  localparam int          SYNC_W    = 8;
  localparam logic [7:0]  SYNC_WORD = 8'hB4;
  localparam int          LEN_W     = 24;
  localparam int          WORD_W    = 8;
  localparam int          ADDR_W    = 12;
  localparam int          SLOW_HALF = 16;
  localparam int          FAST_HALF = SLOW_HALF / 8;
  localparam int          HALF_EXT  = 10;
  localparam int          LEAD      = 4;
  localparam int          NEVER     = 1 << 30;

  logic clk = 1'b0;
  logic rstN, progN, masterMode, cclkIn, din;
  logic cclkOut, cclkOe, dout, done, memCeN, fbWrEn;
  logic [ADDR_W-1:0] fbAddr;
  logic [WORD_W-1:0] fbData;

  cfgload_top #(
    .SYNC_W(SYNC_W), .SYNC_WORD(SYNC_WORD), .LEN_W(LEN_W),
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .SLOW_HALF(SLOW_HALF), .FAST_RATIO(8)
  ) dut (
    .clk(clk), .rstN(rstN), .progN(progN), .masterMode(masterMode),
    .cclkIn(cclkIn), .din(din), .cclkOut(cclkOut), .cclkOe(cclkOe),
    .dout(dout), .done(done), .memCeN(memCeN), .fbWrEn(fbWrEn),
    .fbAddr(fbAddr), .fbData(fbData)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Reference model state
  logic stream[$];
  logic [ADDR_W+WORD_W-1:0] expQ[$];
  logic [ADDR_W+WORD_W-1:0] gotQ[$];
  int preEnd;
  int doneAt;

  always @(negedge clk) if (fbWrEn === 1'b1) gotQ.push_back({fbAddr, fbData});

  task automatic build(input int len, input bit flag, input int nOver,
                       input bit withSync, input int seedIn);
    int unsigned seed = seedIn;
    logic [WORD_W-1:0] acc;
    int fill, addr;
    stream.delete();
    expQ.delete();
    if (withSync) begin
      for (int i = 0; i < LEAD; i++) stream.push_back(1'b1);
      for (int i = SYNC_W - 1; i >= 0; i--) stream.push_back(SYNC_WORD[i]);
      for (int i = LEN_W - 1; i >= 0; i--) stream.push_back(len[i]);
      stream.push_back(flag);
      acc = '0; fill = 0; addr = 0;
      for (int i = 0; i < len; i++) begin
        logic b;
        seed = seed * 1103515245 + 12345;
        b = seed[16];
        stream.push_back(b);
        acc = {acc[WORD_W-2:0], b};
        fill++;
        if (fill == WORD_W || i == len - 1) begin
          expQ.push_back({ADDR_W'(addr), acc});
          addr++; acc = '0; fill = 0;
        end
      end
      for (int i = 0; i < nOver; i++) begin
        seed = seed * 1103515245 + 12345;
        stream.push_back(seed[15]);
      end
      preEnd = LEAD + SYNC_W;
      doneAt = preEnd + LEN_W + 1 + len;
    end else begin
      for (int i = 0; i < nOver; i++) stream.push_back((i % 4) < 2);
      preEnd = NEVER;
      doneAt = NEVER;
    end
  endtask

  function automatic logic expDout(input int k, input bit master);
    int idx = master ? k - 1 : k;
    if (idx < 0) return 1'b1;
    if (idx < preEnd || idx >= doneAt) return stream[idx];
    return 1'b1;
  endfunction

  task automatic runStream(input bit master, input int len, input bit flag,
                           input int nOver, input bit withSync, input int seed,
                           input int abortAt);
    int prevRise = 0;
    int optIdx;
    @(negedge clk);
    progN = 1'b0; masterMode = master; cclkIn = 1'b0; din = 1'b1;
    repeat (4) @(negedge clk);
    build(len, flag, nOver, withSync, seed);
    gotQ.delete();
    optIdx = preEnd + LEN_W;
    din = stream[0];
    progN = 1'b1;
    @(negedge clk);
    chk(cclkOe === master, "R12 clock drive enable", int'(cclkOe), int'(master));
    for (int k = 0; k < stream.size(); k++) begin
      if (!master) begin
        cclkIn = 1'b1;
        repeat (HALF_EXT) @(negedge clk);
        cclkIn = 1'b0;
        din = (k + 1 < stream.size()) ? stream[k+1] : 1'b1;
        repeat (HALF_EXT) @(negedge clk);
        chk(cclkOut === 1'b0, "R12 slave leaves cclkOut low", int'(cclkOut), 0);
      end else begin
        int rise;
        while (cclkOut !== 1'b1) @(negedge clk);
        rise = cyc;
        din = (k + 1 < stream.size()) ? stream[k+1] : 1'b1;
        if (k >= 1) begin
          int p = rise - prevRise;
          if (!flag || (k - 1) < optIdx)
            chk(p == 2 * SLOW_HALF, "R5 slow period", p, 2 * SLOW_HALF);
          else if ((k - 1) == optIdx)
            chk(p == SLOW_HALF + FAST_HALF, "R6 switch period", p, SLOW_HALF + FAST_HALF);
          else
            chk(p == 2 * FAST_HALF, "R5 fast period", p, 2 * FAST_HALF);
        end
        prevRise = rise;
        while (cclkOut !== 1'b0) @(negedge clk);
      end
      begin
        logic e = expDout(k, master);
        int srcIdx = master ? k - 1 : k;
        bit passing = (srcIdx >= 0) && (srcIdx < preEnd || srcIdx >= doneAt);
        chk(dout === e, passing ? "R4 R1 forwarded bit" : "R2 R3 idle high",
            int'(dout), int'(e));
        chk(done === (k >= doneAt), "R9 done timing", int'(done), int'(k >= doneAt));
        chk(memCeN === (k >= doneAt), "R10 memory enable", int'(memCeN), int'(k >= doneAt));
      end
      if (k == abortAt) begin
        progN = 1'b0;
        repeat (3) @(negedge clk);
        chk(done === 1'b0, "R11 done cleared", int'(done), 0);
        chk(memCeN === 1'b0, "R11 enable low", int'(memCeN), 0);
        chk(cclkOut === 1'b0, "R11 clock held", int'(cclkOut), 0);
        return;
      end
    end
    repeat (4) @(negedge clk);
    chk(gotQ.size() == expQ.size(), "R8 R7 write count", gotQ.size(), expQ.size());
    for (int i = 0; i < expQ.size() && i < gotQ.size(); i++)
      chk(gotQ[i] === expQ[i], "R1 R8 frame word", int'(gotQ[i]), int'(expQ[i]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; progN = 1'b0; masterMode = 1'b0; cclkIn = 1'b0; din = 1'b1;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(done === 1'b0,   "R9 reset done",     int'(done),   0);
    chk(memCeN === 1'b0, "R10 reset enable",  int'(memCeN), 0);
    chk(dout === 1'b1,   "R2 reset dout",     int'(dout),   1);
    chk(fbWrEn === 1'b0, "R8 reset write",    int'(fbWrEn), 0);
    chk(cclkOut === 1'b0,"R11 reset clock",   int'(cclkOut),0);

    // slave, partial last word, overflow forwarded
    runStream(1'b0, 20, 1'b1, 12, 1'b1, 7, -1);
    // master, fast rate switch
    runStream(1'b1, 13, 1'b1, 8, 1'b1, 99, -1);
    // master, zero length, slow throughout
    runStream(1'b1, 0, 1'b0, 6, 1'b1, 3, -1);
    // master, abort by program during fast load
    runStream(1'b1, 30, 1'b1, 4, 1'b1, 41, LEAD + SYNC_W + LEN_W + 5);
    // master after abort: rate back to slow
    runStream(1'b1, 9, 1'b0, 4, 1'b1, 55, -1);
    // slave, stream with no sync word: all forwarded, nothing stored (R7)
    runStream(1'b0, 0, 1'b0, 40, 1'b0, 1, -1);
    // slave, exact word multiple
    runStream(1'b0, 16, 1'b0, 5, 1'b1, 123, -1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule